// File: doc/BRIEF.md
# Increment-and-Skip Execution Unit

This block is the execute stage for the increment-with-skip instruction of a 4-bit controller. An upstream decoder hands it an operation code, a register index and a direct address, and pulses `start`. The unit adds one to the selected destination and writes the result back. If the add carries out of the top bit of the destination, it tells the fetch logic to throw away the next instruction.

There are four destinations. The first is a nibble register. The second is a data-memory nibble at a direct address. The third is a data-memory nibble addressed through the HL pointer. The fourth is an 8-bit register pair, which is incremented as one value. The unit holds its own nibble register file, and the top pair of that file is the HL pointer. It also holds a carry flag, but only other ALU operations write that flag, through the `cy_we` port.

Memory destinations use a read-modify-write sequence. The data memory has a one-cycle read latency. A taken skip adds one cycle, and in that cycle `skip` and `done` are high together.

Top module: `incskip_unit`

## Requirements
- R1: With `op_mode`=0, register `op_reg` is replaced by its value plus one, modulo 16. Without a carry, `done` is high in the first cycle after the start edge.
- R2: When the increment wraps the destination to zero, `skip` is high for exactly one cycle, in the same cycle as `done`. That cycle is one cycle later than the no-carry completion. Without a carry, `skip` stays low.
- R3: The carry flag `cy_flag` changes only on a clock edge where `cy_we` is high, and it then takes `cy_wdata`. No increment changes it, whether or not a carry occurs.
- R4: With `op_mode`=1, the memory nibble at `op_addr` is read and then incremented. `mem_addr` shows that address from the first busy cycle onward. `mem_we` is high only in the second busy cycle, and `done` arrives in the second cycle (third with skip).
- R5: With `op_mode`=2, the memory nibble at address {register 7, register 6} (HL) is incremented with the R4 timing. HL itself is not changed.
- R6: With `op_mode`=3, pair p=`op_reg[2:1]` is incremented as one 8-bit value, with register 2p+1 as the high nibble and register 2p as the low nibble. A carry, and so a skip, happens only on 0xFF to 0x00. The timing is that of R1.
- R7: `start` is ignored while `busy` is high, and that includes the cycle in which `done` is high.
- R8: A synchronous active-low reset clears all registers, HL and the carry flag, and returns the unit to idle.
- R9: `busy` is high from the start edge through the `done` cycle. `done` is a single-cycle pulse.
- R10: The external port writes `wr_data` into register `wr_idx`, and `rd_data` always shows register `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the decoded operation |
| op_mode | input | 2 | 0 register, 1 direct memory, 2 HL-indirect memory, 3 register pair |
| op_reg | input | 3 | Register index; bits [2:1] select the pair |
| op_addr | input | 8 | Direct memory address |
| wr_en | input | 1 | External register write enable |
| wr_idx | input | 3 | External write register index |
| wr_data | input | 4 | External write data |
| rd_idx | input | 3 | Register read index |
| rd_data | output | 4 | Register read data |
| hl_ptr | output | 8 | HL pointer value |
| cy_we | input | 1 | Carry flag write enable |
| cy_wdata | input | 1 | Carry flag write value |
| cy_flag | output | 1 | Carry flag |
| mem_addr | output | 8 | Data memory address |
| mem_we | output | 1 | Data memory write enable |
| mem_wdata | output | 4 | Data memory write data |
| mem_rdata | input | 4 | Data memory read data, one cycle after address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete pulse |
| skip | output | 1 | Discard-next-instruction pulse |

## Verification
The bench targets the wrap cases: a nibble at 0xF, and a pair at 0xFF. It also covers a pair at 0x0F, which carries between its nibbles but must not skip; a design that treated the pair as two nibbles would skip there, or would fail to carry into the high nibble. Ops run with the carry flag both set and clear, which catches a design that writes the carry result into the flag. An indirect op is followed by a check of HL and of the addressed cell, which catches a design that increments the pointer instead of the memory. A start held or repeated during busy and during done catches a design that re-triggers and increments twice.

// File: rtl/incskip_pkg.sv
// Shared types for the increment-and-skip execute unit.
// Assumes a two-bit operation code supplied by the decoder.
package incskip_pkg;

    typedef enum logic [1:0] {
        OP_REG  = 2'd0,
        OP_DIR  = 2'd1,
        OP_IND  = 2'd2,
        OP_PAIR = 2'd3
    } op_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_EXEC = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_SKIP = 3'd4
    } exec_state_e;

endpackage

// File: rtl/incskip_incr.sv
// Ripple incrementer: y = a + 1 with carry out.
// Assumes W >= 1. Purely combinational.
module incskip_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = 1'b1;

    // One half-adder stage per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i]   = a[i] ^ c[i];
        assign c[i+1] = a[i] & c[i];
    end

    assign co = c[W];
endmodule

// File: rtl/incskip_regfile.sv
// Nibble register file. Even/odd neighbours form pairs (odd = high nibble).
// The top pair is the HL pointer. Write priority: pair, nibble, external.
// Assumes NUM_REGS is a power of two, at least 2.
module incskip_regfile #(
    parameter int W        = 4,
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int PIDX_W  = (IDX_W > 1) ? IDX_W - 1 : 1,
    localparam int HL_PAIR = NUM_REGS / 2 - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_we,
    input  logic [IDX_W-1:0]  ext_idx,
    input  logic [W-1:0]      ext_data,
    input  logic              nib_we,
    input  logic [IDX_W-1:0]  nib_idx,
    input  logic [W-1:0]      nib_data,
    input  logic              pair_we,
    input  logic [PIDX_W-1:0] pair_idx,
    input  logic [2*W-1:0]    pair_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [W-1:0]      rd_data,
    input  logic [IDX_W-1:0]  op_idx,
    output logic [W-1:0]      op_nib,
    input  logic [PIDX_W-1:0] op_pidx,
    output logic [2*W-1:0]    op_pair,
    output logic [2*W-1:0]    hl
);
    logic [W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam int PAIR_NO = g / 2;
        localparam bit IS_HI   = (g % 2) == 1;

        // Update one register with the highest-priority writer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (pair_we && pair_idx == PIDX_W'(PAIR_NO)) begin
                regs[g] <= IS_HI ? pair_data[2*W-1:W] : pair_data[W-1:0];
            end else if (nib_we && nib_idx == IDX_W'(g)) begin
                regs[g] <= nib_data;
            end else if (ext_we && ext_idx == IDX_W'(g)) begin
                regs[g] <= ext_data;
            end
        end
    end

    // Read ports.
    always_comb begin
        rd_data = regs[rd_idx];
        op_nib  = regs[op_idx];
        op_pair = {regs[{op_pidx, 1'b1}], regs[{op_pidx, 1'b0}]};
        hl      = {regs[2*HL_PAIR+1], regs[2*HL_PAIR]};
    end
endmodule

// File: rtl/incskip_ctrl.sv
// Sequencer for one increment-and-skip operation.
// Register/pair forms: EXEC. Memory forms: RD then WR. A carry adds SKIP.
// Assumes 'carry' is valid in EXEC and WR.
module incskip_ctrl
    import incskip_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  op_mode_e    mode,
    input  logic        carry,
    output exec_state_e state,
    output logic        accept,
    output logic        busy,
    output logic        done,
    output logic        skip
);
    exec_state_e nxt;

    assign accept = (state == ST_IDLE) && start;

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (start) nxt = (mode == OP_REG || mode == OP_PAIR) ? ST_EXEC : ST_RD;
            ST_EXEC: nxt = carry ? ST_SKIP : ST_IDLE;
            ST_RD:   nxt = ST_WR;
            ST_WR:   nxt = carry ? ST_SKIP : ST_IDLE;
            ST_SKIP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Status outputs.
    always_comb begin
        busy = (state != ST_IDLE);
        skip = (state == ST_SKIP);
        done = skip || (((state == ST_EXEC) || (state == ST_WR)) && !carry);
    end
endmodule

// File: rtl/incskip_unit.sv
// Top of the increment-and-skip execute unit. Latches the decoded op on
// start, runs the increment on a register, a pair or a memory nibble,
// and signals skip on carry. The carry flag is written only by cy_we.
// Assumes a data memory with one-cycle read latency.
module incskip_unit
    import incskip_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int PIDX_W  = (IDX_W > 1) ? IDX_W - 1 : 1,
    localparam int ADDR_W  = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_mode,
    input  logic [IDX_W-1:0]  op_reg,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [NIB_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] hl_ptr,
    input  logic              cy_we,
    input  logic              cy_wdata,
    output logic              cy_flag,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [NIB_W-1:0]  mem_wdata,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              skip
);
    exec_state_e       state;
    logic              accept;
    op_mode_e          mode_q;
    logic [IDX_W-1:0]  reg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NIB_W-1:0]  rf_nib, nib_opnd, nib_sum;
    logic [ADDR_W-1:0] rf_pair, pair_sum;
    logic              nib_co, pair_co, carry;
    logic [PIDX_W-1:0] pidx;

    assign pidx = (IDX_W > 1) ? PIDX_W'(reg_q >> 1) : '0;

    // Capture the decoded operation and its effective memory address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OP_REG;
            reg_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            mode_q <= op_mode_e'(op_mode);
            reg_q  <= op_reg;
            addr_q <= (op_mode_e'(op_mode) == OP_DIR) ? op_addr : hl_ptr;
        end
    end

    // Carry flag: written only by the external port.
    always_ff @(posedge clk) begin
        if (!rst_n)     cy_flag <= 1'b0;
        else if (cy_we) cy_flag <= cy_wdata;
    end

    incskip_regfile #(.W(NIB_W), .NUM_REGS(NUM_REGS)) i_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_we    (wr_en),
        .ext_idx   (wr_idx),
        .ext_data  (wr_data),
        .nib_we    ((state == ST_EXEC) && (mode_q == OP_REG)),
        .nib_idx   (reg_q),
        .nib_data  (nib_sum),
        .pair_we   ((state == ST_EXEC) && (mode_q == OP_PAIR)),
        .pair_idx  (pidx),
        .pair_data (pair_sum),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .op_idx    (reg_q),
        .op_nib    (rf_nib),
        .op_pidx   (pidx),
        .op_pair   (rf_pair),
        .hl        (hl_ptr)
    );

    // Nibble operand: register for the register form, memory data otherwise.
    assign nib_opnd = (mode_q == OP_REG) ? rf_nib : mem_rdata;

    incskip_incr #(.W(NIB_W)) i_nib_inc (
        .a  (nib_opnd),
        .y  (nib_sum),
        .co (nib_co)
    );

    incskip_incr #(.W(ADDR_W)) i_pair_inc (
        .a  (rf_pair),
        .y  (pair_sum),
        .co (pair_co)
    );

    assign carry = (mode_q == OP_PAIR) ? pair_co : nib_co;

    incskip_ctrl i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (op_mode_e'(op_mode)),
        .carry  (carry),
        .state  (state),
        .accept (accept),
        .busy   (busy),
        .done   (done),
        .skip   (skip)
    );

    // Memory port: address held for the whole op, write in WR.
    assign mem_addr  = addr_q;
    assign mem_we    = (state == ST_WR);
    assign mem_wdata = nib_sum;
endmodule

// File: rtl/incskip_chk.sv
// Temporal checks on the increment-and-skip unit, bound to its top.
module incskip_chk #(
    parameter int HL_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            skip,
    input logic            mem_we,
    input logic            cy_we,
    input logic            cy_flag,
    input logic            wr_en,
    input logic [HL_W-1:0] hl_ptr
);
    // R2
    skip_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R3
    cy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cy_we |=> $stable(cy_flag));

    // R5
    hl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wr_en) |=> $stable(hl_ptr));
endmodule

bind incskip_unit incskip_chk #(.HL_W(2 * NIB_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .skip    (skip),
    .mem_we  (mem_we),
    .cy_we   (cy_we),
    .cy_flag (cy_flag),
    .wr_en   (wr_en),
    .hl_ptr  (hl_ptr)
);

// File: tb/test_incskip_unit.sv
`timescale 1ns/1ps
module test_incskip_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op_mode = '0;
    logic [2:0] op_reg = '0;
    logic [7:0] op_addr = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_idx = '0;
    logic [3:0] wr_data = '0;
    logic [2:0] rd_idx = '0;
    logic [3:0] rd_data;
    logic [7:0] hl_ptr;
    logic       cy_we = 1'b0, cy_wdata = 1'b0, cy_flag;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [3:0] mem_wdata;
    logic [3:0] mem_rdata = '0;
    logic       busy, done, skip;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    incskip_unit i_incskip_unit (.*);

    // Bench data memory with one-cycle read latency.
    logic [3:0] mem [256];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // Reference model state.
    int mr [8];
    int mm [256];
    int mc;
    int left, pos;
    bit mskip, memop;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic poke(input int a, input int v);
        mem[a] = 4'(v);
        mm[a]  = v & 15;
    endtask

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            foreach (mr[i]) mr[i] = 0;
            mc = 0; left = 0; pos = 0; mskip = 0; memop = 0;
        end else begin
            if (cy_we) mc = int'(cy_wdata);
            if (left > 0) begin
                left--; pos++;
            end else if (start) begin
                int v, a, p;
                pos = 1;
                case (op_mode)
                    2'd0: begin
                        v = mr[op_reg]; mskip = (v == 15);
                        mr[op_reg] = (v + 1) & 15; memop = 0;
                        left = 1 + int'(mskip);
                    end
                    2'd3: begin
                        p = int'(op_reg) / 2;
                        v = mr[2*p+1] * 16 + mr[2*p]; mskip = (v == 255);
                        v = (v + 1) & 255;
                        mr[2*p+1] = v / 16; mr[2*p] = v % 16; memop = 0;
                        left = 1 + int'(mskip);
                    end
                    default: begin
                        a = (op_mode == 2'd1) ? int'(op_addr) : mr[7] * 16 + mr[6];
                        v = mm[a]; mskip = (v == 15);
                        mm[a] = (v + 1) & 15; memop = 1;
                        left = 2 + int'(mskip);
                    end
                endcase
            end
            if (wr_en) mr[wr_idx] = int'(wr_data);
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (left > 0), "R9 busy", busy, left > 0);
            check(done == (left == 1), "R9 done", done, left == 1);
            check(skip == (left == 1 && mskip), "R2 skip", skip, left == 1 && mskip);
            check(mem_we == (memop && left > 0 && pos == 2), "R4 mem_we", mem_we, memop && left > 0 && pos == 2);
            check(cy_flag == mc[0], "R3 cy_flag", cy_flag, mc);
            if (left == 0) begin
                check(rd_data == 4'(mr[rd_idx]), "R10 rd_data", rd_data, mr[rd_idx]);
                check(hl_ptr == 8'(mr[7] * 16 + mr[6]), "R5 hl_ptr", hl_ptr, mr[7] * 16 + mr[6]);
            end
        end
    end

    task automatic wreg(input int idx, input int val);
        @(negedge clk);
        wr_en = 1; wr_idx = 3'(idx); wr_data = 4'(val);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic setcy(input bit v);
        @(negedge clk);
        cy_we = 1; cy_wdata = v;
        @(negedge clk);
        cy_we = 0;
    endtask

    task automatic peek(input int idx, input int exp, input string tag);
        rd_idx = 3'(idx);
        #1;
        check(rd_data == 4'(exp), tag, rd_data, exp);
    endtask

    // Issue one op and measure cycles from the start edge to done.
    task automatic run_op(input int m, input int r, input int a, input int exp_n,
                          input bit exp_skip, input bit restart, input string tag);
        int n;
        @(negedge clk);
        op_mode = 2'(m); op_reg = 3'(r); op_addr = 8'(a); start = 1;
        @(negedge clk);
        start = restart;
        n = 1;
        while (!done && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(n == exp_n, {tag, " cycles"}, n, exp_n);
        check(skip == exp_skip, {tag, " skip"}, skip, exp_skip);
        @(negedge clk);
        start = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) poke(i, i ^ 9);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: everything cleared after reset.
        for (int i = 0; i < 8; i++) peek(i, 0, "R8 reg reset");
        check(hl_ptr == 0, "R8 hl reset", hl_ptr, 0);
        check(cy_flag == 0, "R8 cy reset", cy_flag, 0);
        check(busy == 0, "R8 idle", busy, 0);

        setcy(1);
        wreg(0, 5);
        run_op(0, 0, 0, 1, 0, 0, "R1 reg 5");
        peek(0, 6, "R1 reg 5->6");
        wreg(1, 15);
        run_op(0, 1, 0, 2, 1, 0, "R2 reg F");
        peek(1, 0, "R2 reg F->0");
        check(cy_flag == 1, "R3 cy kept set", cy_flag, 1);

        poke(8'h33, 15);
        run_op(1, 0, 8'h33, 3, 1, 0, "R4 dir F");
        check(mem[8'h33] == 0, "R4 mem F->0", mem[8'h33], 0);
        poke(8'h40, 7);
        run_op(1, 0, 8'h40, 2, 0, 0, "R4 dir 7");
        check(mem[8'h40] == 8, "R4 mem 7->8", mem[8'h40], 8);

        wreg(6, 4'hA); wreg(7, 4'h5);
        poke(8'h5A, 3);
        run_op(2, 0, 8'h00, 2, 0, 0, "R5 ind 3");
        check(mem[8'h5A] == 4, "R5 mem 3->4", mem[8'h5A], 4);
        check(hl_ptr == 8'h5A, "R5 hl unchanged", hl_ptr, 8'h5A);
        poke(8'h5A, 15);
        run_op(2, 0, 8'h00, 3, 1, 0, "R5 ind F");
        check(mem[8'h5A] == 0, "R5 mem F->0", mem[8'h5A], 0);

        setcy(0);
        wreg(2, 15); wreg(3, 0);
        run_op(3, 2, 0, 1, 0, 0, "R6 pair 0F");
        peek(2, 0, "R6 pair lo"); peek(3, 1, "R6 pair hi");
        wreg(4, 15); wreg(5, 15);
        run_op(3, 5, 0, 2, 1, 0, "R6 pair FF");
        peek(4, 0, "R6 pair FF lo"); peek(5, 0, "R6 pair FF hi");
        check(cy_flag == 0, "R3 cy kept clear", cy_flag, 0);

        // R7: start held through busy and done is accepted once.
        wreg(0, 2);
        poke(8'h41, 9);
        run_op(1, 0, 8'h41, 2, 0, 1, "R7 dir held");
        check(mem[8'h41] == 10, "R7 single increment", mem[8'h41], 10);
        run_op(0, 0, 0, 1, 0, 1, "R7 reg held");
        peek(0, 3, "R7 reg single increment");

        // R8: reset in mid-operation.
        @(negedge clk);
        op_mode = 2'd1; op_addr = 8'h42; start = 1;
        @(negedge clk);
        start = 0; rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        #1;
        check(busy == 0, "R8 reset mid-op", busy, 0);
        peek(0, 0, "R8 regs cleared");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule